// File: doc/BRIEF.md
# Polled Hit Collector

This block gathers timestamped hits from a group of sixteen channel FIFOs into one shared collector queue. A one-hot ring pointer moves to the next channel on every clock edge. When the channel it points at holds a hit and the collector has room, that channel's FIFO gets a one-cycle read strobe. The hit's time byte is then stored together with the channel's global number. Three such blocks, built with different base numbers, together serve forty-eight channels.

Each collector word is 16 bits wide and holds the channel number in the upper byte and the time in the lower byte. The word leaves the block as two bytes on a valid/ready stream, channel byte first. A hit waits in its channel FIFO while the collector is full, so no hit is dropped. The channel FIFOs are first-word-fall-through: their data port shows the oldest hit whenever their empty flag is low.

Top module: `hit_collector`

## Requirements
- R1: While rst_ni is low, no channel read strobe is raised, even when a channel is non-empty, and out_valid_o is low.
- R2: The selected channel is channel 0 in the first cycle after reset is released, and it advances by one (wrapping 15 to 0) every cycle, whether or not a read happens.
- R3: ch_rd_o has at most one bit set, only the bit of the selected channel. That bit is set exactly when the channel's empty flag is low and the collector has room.
- R4: A hit read from local channel k is stored as the word {CH_BASE + k, time byte}.
- R5: Each word is emitted as two bytes, the channel byte (upper) first and then the time byte (lower). A word is removed only after its second byte is accepted (out_valid_o and out_ready_i high at a clock edge).
- R6: Hits leave the block in the order they were read from the channels, with none lost and none duplicated.
- R7: Room means that the words held in the collector plus any word in flight total fewer than DEPTH (256). When this limit is reached, channel reads stop until a word is removed.
- R8: While out_valid_o is high and out_ready_i is low, out_valid_o stays high and out_data_o does not change.
- R9: When a read takes place with the collector empty, out_valid_o is still low one cycle later and rises two cycles after the read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Collector clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ch_empty_i | input | 16 | Empty flag of each channel FIFO |
| ch_rd_o | output | 16 | One-cycle read strobe to each channel FIFO |
| ch_data_i | input | 128 | Head time byte of each channel, channel k in bits 8k+7:8k |
| out_data_o | output | 8 | Output byte |
| out_valid_o | output | 1 | Output byte valid |
| out_ready_i | input | 1 | Downstream ready |

## Verification
A read strobe depends only on registered state and the current empty flags, so it is due in the same cycle that the bench presents a channel. The bench checks it half a cycle after each rising edge, before the channel model pops. The stored word reaches the collector two edges later, so out_valid_o is checked at the first and second sampling points after a read into an empty collector. Bytes count as accepted at the edge that follows a sample in which valid and ready are both high. The bench's count of outstanding words therefore drops one cycle before the next read decision, which matches the room check inside the block.

// File: rtl/hit_pkg.sv
package hit_pkg;
  localparam int unsigned BYTE_W = 8;
  typedef logic [BYTE_W-1:0] byte_t;
endpackage

// File: rtl/ring_selector.sv
module ring_selector #(
  parameter int unsigned N_CH = 16
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  output logic [N_CH-1:0] sel_o
);
  logic [N_CH-1:0] sel_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sel_q <= N_CH'(1);
    else         sel_q <= {sel_q[N_CH-2:0], sel_q[N_CH-1]};
  end

  assign sel_o = sel_q;

  p_one_hot_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(sel_q) == 1);
endmodule

// File: rtl/hit_capture.sv
module hit_capture
  import hit_pkg::*;
#(
  parameter int unsigned N_CH    = 16,
  parameter int unsigned CH_BASE = 0
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic [N_CH-1:0]        sel_i,
  input  logic [N_CH-1:0]        empty_i,
  input  logic [N_CH*BYTE_W-1:0] data_i,
  input  logic                   space_i,
  output logic [N_CH-1:0]        rd_o,
  output logic                   wr_o,
  output logic [2*BYTE_W-1:0]    word_o
);
  localparam int unsigned IDX_W = (N_CH > 1) ? $clog2(N_CH) : 1;

  logic [IDX_W-1:0] idx;
  logic             hit;
  logic             wr_q;
  logic [2*BYTE_W-1:0] word_q;

  always_comb begin
    idx = '0;
    for (int i = 0; i < int'(N_CH); i++) begin
      if (sel_i[i]) idx = IDX_W'(i);
    end
  end

  // no read during reset or while the collector is at its limit
  assign rd_o = (space_i && rst_ni) ? (sel_i & ~empty_i) : '0;
  assign hit  = |rd_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q   <= 1'b0;
      word_q <= '0;
    end else begin
      wr_q <= hit;
      if (hit) word_q <= {byte_t'(CH_BASE) + byte_t'(idx), data_i[idx*BYTE_W +: BYTE_W]};
    end
  end

  assign wr_o   = wr_q;
  assign word_o = word_q;

  p_single_rd_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(rd_o));
  p_rd_not_empty_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_o & empty_i) == '0);
  p_wr_follows_rd_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit |=> wr_o);
endmodule

// File: rtl/collector_fifo.sv
module collector_fifo
  import hit_pkg::*;
#(
  parameter int unsigned DEPTH = 256
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 wr_i,
  input  logic [2*BYTE_W-1:0]  wdata_i,
  output logic [$clog2(DEPTH+1)-1:0] count_o,
  output logic [BYTE_W-1:0]    rd_data_o,
  output logic                 rd_valid_o,
  input  logic                 rd_ready_i
);
  localparam int unsigned AW    = $clog2(DEPTH);
  localparam int unsigned CNT_W = $clog2(DEPTH+1);

  logic [2*BYTE_W-1:0] mem [DEPTH];
  logic [AW-1:0]       wr_ptr_q, rd_ptr_q;
  logic [CNT_W-1:0]    count_q;
  logic                lo_q;   // 0: upper byte pending, 1: lower byte pending
  logic                pop;
  logic [2*BYTE_W-1:0] head;

  assign head       = mem[rd_ptr_q];
  assign rd_valid_o = (count_q != '0);
  assign rd_data_o  = lo_q ? head[BYTE_W-1:0] : head[2*BYTE_W-1:BYTE_W];
  assign pop        = rd_valid_o && rd_ready_i && lo_q;
  assign count_o    = count_q;

  always_ff @(posedge clk_i) begin
    if (wr_i) mem[wr_ptr_q] <= wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      count_q  <= '0;
      lo_q     <= 1'b0;
    end else begin
      if (wr_i) wr_ptr_q <= (wr_ptr_q == AW'(DEPTH-1)) ? '0 : wr_ptr_q + 1'b1;
      if (pop)  rd_ptr_q <= (rd_ptr_q == AW'(DEPTH-1)) ? '0 : rd_ptr_q + 1'b1;
      if (rd_valid_o && rd_ready_i) lo_q <= ~lo_q;
      count_q <= count_q + CNT_W'(wr_i) - CNT_W'(pop);
    end
  end

  p_no_overflow_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i |-> (count_q < CNT_W'(DEPTH)) || pop);
  p_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_valid_o && !rd_ready_i) |=> (rd_valid_o && $stable(rd_data_o)));
  p_pair_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_valid_o && rd_ready_i && !lo_q) |=> rd_valid_o);
endmodule

// File: rtl/hit_collector.sv
module hit_collector
  import hit_pkg::*;
#(
  parameter int unsigned N_CH    = 16,
  parameter int unsigned CH_BASE = 0,
  parameter int unsigned DEPTH   = 256
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic [N_CH-1:0]        ch_empty_i,
  output logic [N_CH-1:0]        ch_rd_o,
  input  logic [N_CH*BYTE_W-1:0] ch_data_i,
  output logic [BYTE_W-1:0]      out_data_o,
  output logic                   out_valid_o,
  input  logic                   out_ready_i
);
  localparam int unsigned CNT_W = $clog2(DEPTH+1);

  logic [N_CH-1:0]     sel;
  logic                wr;
  logic [2*BYTE_W-1:0] word;
  logic [CNT_W-1:0]    count;
  logic [CNT_W:0]      held;
  logic                space;

  // in-flight word counts against the limit
  assign held  = {1'b0, count} + (CNT_W+1)'(wr);
  assign space = held < (CNT_W+1)'(DEPTH);

  ring_selector #(.N_CH(N_CH)) u_sel (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .sel_o (sel)
  );

  hit_capture #(.N_CH(N_CH), .CH_BASE(CH_BASE)) u_cap (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .sel_i  (sel),
    .empty_i(ch_empty_i),
    .data_i (ch_data_i),
    .space_i(space),
    .rd_o   (ch_rd_o),
    .wr_o   (wr),
    .word_o (word)
  );

  collector_fifo #(.DEPTH(DEPTH)) u_fifo (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_i      (wr),
    .wdata_i   (word),
    .count_o   (count),
    .rd_data_o (out_data_o),
    .rd_valid_o(out_valid_o),
    .rd_ready_i(out_ready_i)
  );

  p_rd_in_sel_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ch_rd_o & ~sel) == '0);
  p_stall_full_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (held >= (CNT_W+1)'(DEPTH)) |-> (ch_rd_o == '0));
  p_reset_idle_r1: assert property (@(posedge clk_i)
    !rst_ni |-> (ch_rd_o == '0 && !out_valid_o));
endmodule

// File: tb/hit_collector_test.sv
module hit_collector_test;
  localparam int N     = 16;
  localparam int BASE  = 32;
  localparam int DEPTH = 256;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic           rst_ni = 1'b0;
  logic [N-1:0]   ch_empty;
  logic [N-1:0]   ch_rd;
  logic [N*8-1:0] ch_data;
  logic [7:0]     out_data;
  logic           out_valid;
  logic           out_ready;

  hit_collector #(.N_CH(N), .CH_BASE(BASE), .DEPTH(DEPTH)) uut (
    .clk_i(clk), .rst_ni(rst_ni),
    .ch_empty_i(ch_empty), .ch_rd_o(ch_rd), .ch_data_i(ch_data),
    .out_data_o(out_data), .out_valid_o(out_valid), .out_ready_i(out_ready)
  );

  int checks = 0, errors = 0;
  logic [7:0] cq [N][64];
  int cq_h [N];
  int cq_c [N];
  logic [7:0] exp_b [8192];
  int exp_w = 0, exp_r = 0, outstanding = 0, cyc = 0;
  int pend_ch = -1, lat_t = -1, ready_mode = 1;
  logic prev_stall = 1'b0;
  logic [7:0] prev_data = '0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic push_hit(input int ch, input logic [7:0] val);
    if (cq_c[ch] < 64) begin
      cq[ch][(cq_h[ch] + cq_c[ch]) % 64] = val;
      cq_c[ch]++;
    end
  endtask

  function automatic logic [N-1:0] exp_rd_f(input int s, input logic [N-1:0] emp, input int outs);
    return (!emp[s] && outs < DEPTH) ? (N'(1) << s) : '0;
  endfunction

  function automatic int queued();
    int s = 0;
    for (int i = 0; i < N; i++) s += cq_c[i];
    return s;
  endfunction

  always @(negedge clk) begin
    if (pend_ch >= 0) begin
      cq_h[pend_ch] = (cq_h[pend_ch] + 1) % 64;
      cq_c[pend_ch]--;
      pend_ch = -1;
    end
    for (int i = 0; i < N; i++) begin
      ch_empty[i]       = (cq_c[i] == 0);
      ch_data[i*8 +: 8] = cq[i][cq_h[i]];
    end
    case (ready_mode)
      0:       out_ready = ($urandom % 3) != 0;
      1:       out_ready = 1'b0;
      default: out_ready = 1'b1;
    endcase
    #1;
    if (rst_ni) begin
      int s;
      logic [N-1:0] er;
      if (prev_stall) chk(out_valid && out_data == prev_data, "R8 hold", {out_valid, out_data}, {1'b1, prev_data});
      if (lat_t >= 0) begin
        if (cyc == lat_t + 1) chk(!out_valid, "R9 early", out_valid, 0);
        if (cyc == lat_t + 2) begin
          chk(out_valid, "R9 due", out_valid, 1);
          lat_t = -1;
        end
      end
      s  = cyc % N;
      er = exp_rd_f(s, ch_empty, outstanding);
      chk(ch_rd == er, "R3 strobe (R2 rotation, R7 room)", ch_rd, er);
      if (ch_rd[s]) begin
        if (outstanding == 0 && !out_valid && lat_t < 0) lat_t = cyc;
        exp_b[exp_w % 8192]       = 8'(BASE + s);
        exp_b[(exp_w + 1) % 8192] = cq[s][cq_h[s]];
        exp_w += 2;
        outstanding++;
        pend_ch = s;
      end
      if (out_valid && out_ready) begin
        chk(exp_r < exp_w && out_data == exp_b[exp_r % 8192], "R5/R4 byte", out_data, exp_b[exp_r % 8192]);
        exp_r++;
        if (exp_r % 2 == 0) outstanding--;
      end
      prev_stall = out_valid && !out_ready;
      prev_data  = out_data;
      cyc++;
    end
  end

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected finish");
    summary();
    $finish;
  end

  initial begin
    void'($urandom(32'd7));
    for (int i = 0; i < N; i++) begin cq_h[i] = 0; cq_c[i] = 0; end
    repeat (3) @(posedge clk);
    #2 push_hit(0, 8'h11);
    @(negedge clk); #3;
    chk(ch_rd == '0, "R1 no read in reset", ch_rd, 0);
    chk(!out_valid, "R1 valid low", out_valid, 0);
    @(posedge clk); #2 rst_ni = 1'b1;
    // first visit is channel 0 (R2): the 0x11 hit is read at cycle 0
    ready_mode = 2;
    @(posedge clk); #2;
    push_hit(15, 8'hF0);
    push_hit(0, 8'h00);
    push_hit(7, 8'h5A);
    repeat (60) @(posedge clk);
    chk(exp_r == exp_w && exp_w == 8, "R6 directed drained", exp_r, 8);

    // random traffic with random backpressure
    ready_mode = 0;
    repeat (3000) begin
      @(posedge clk); #2;
      if ($urandom % 4 == 0) push_hit(int'($urandom % N), 8'($urandom));
    end
    ready_mode = 2;
    repeat (300) @(posedge clk);
    chk(exp_r == exp_w && outstanding == 0, "R6 random drained", exp_r, exp_w);

    // collector fills to its limit, remaining hits wait in the channels
    ready_mode = 1;
    @(posedge clk); #2;
    for (int i = 0; i < 300; i++) push_hit(i % N, 8'(i));
    repeat (400) @(posedge clk);
    #2;
    chk(outstanding == DEPTH, "R7 held at limit", outstanding, DEPTH);
    chk(queued() == 300 - DEPTH, "R7 hits wait in channels", queued(), 300 - DEPTH);
    chk(out_valid, "R8 valid while stalled", out_valid, 1);
    ready_mode = 2;
    repeat (1200) @(posedge clk);
    chk(exp_r == exp_w && outstanding == 0 && queued() == 0, "R6 no loss after full", exp_r, exp_w);
    summary();
    $finish;
  end
endmodule